// File: doc/BRIEF.md
# Gated Single-Shot Pulse-Width Timer

This block measures how long a gate input stays high, counted in periods of a counter clock. The counter clock arrives as a one-cycle strobe (`cntTick`) in the block's system clock domain, one strobe per falling edge of the counter clock. The gate input is asynchronous and is synchronised before use.

Software arms the block by writing the control register with the run, prescaler-enable and gate-enable bits set and the mode field at binary 100. Once the gate goes high, the first tick loads the counter with all ones, and each later tick takes one off. When the gate drops, the count freezes and a gate-done flag is raised. The measurement is single-shot: later gate activity is ignored until software clears the run bit and sets it again.

Compare and terminal-count flags report when the count passes a programmed value. A timeout flag reports a count that reached zero, where the counter then stays.

Top module: `gated_pw_timer`

## Requirements
- R1: The block is enabled only while control bits 0 (run), 1 (prescaler enable) and 2 (gate enable) are all one and control bits 6:4 hold 3'b100. Status bit 0 (ON) is one while enabled and the measurement has not finished. Any other control value leaves ON at zero and the counter untouched.
- R2: Status bit 5 shows the gate level after a two-flop synchroniser, in every state. A gate change shows two clock edges after it is applied.
- R3: Once enabled with the synchronised gate high, the first tick loads the count with 0xFFFF and every later tick decrements it by one.
- R4: When the synchronised gate goes low during a measurement, the count holds its value, status bit 1 (TG) is set and ON clears.
- R5: After the measurement ends, further gate pulses and ticks change neither the count nor the status flags until the run bit is cleared.
- R6: A decrement whose result equals the compare register sets status bit 2 (COM) and bit 3 (TC). Loading 0xFFFF is not a decrement and never sets them.
- R7: A decrement that reaches 0x0000 sets status bit 4 (TO) and clears COM in the same update. The count then stays at 0x0000 for further ticks.
- R8: Status bits 1 to 4 are write-one-to-clear at address 2. Bits written as zero leave their flag unchanged. A set event in the same cycle as a clear wins.
- R9: Clearing the run bit returns the block to idle, clears ON and stops counting. Setting the run bit again arms a fresh measurement.
- R10: Register map: address 0 control (read/write, 8 bits), address 1 compare (read/write), address 2 status (read, write-one-to-clear), address 3 count (read only). All read zero after reset with the gate low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | One-cycle strobe per counter-clock falling edge |
| gateIn | input | 1 | Asynchronous gate input, high while being measured |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | CNT_W | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | CNT_W | Read data for rdAddr, combinational |

## Verification
The collision that matters is a decrement that matches the compare value and reaches zero in the same update. Here the compare rule sets COM and the timeout rule clears it. The bench provokes it by setting the compare register to zero and holding the gate high for more than 65536 ticks. It then expects TO and TC set, COM clear and the count held at zero, and it expects TG on top of those once the gate drops.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } runState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
    logic wrCmp;
  } dpStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int CB_RUN   = 0;
  localparam int CB_PRE   = 1;
  localparam int CB_GATE  = 2;
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;
  localparam logic [MODE_W-1:0] MODE_PW = 3'b100;

  localparam int SB_ON   = 0;
  localparam int SB_TG   = 1;
  localparam int SB_COM  = 2;
  localparam int SB_TC   = 3;
  localparam int SB_TO   = 4;
  localparam int SB_GATE = 5;

endpackage

// File: rtl/pwt_gate_sync.sv
module pwt_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateIn,
  output logic gateSync
);
  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stage[i] <= 1'b0;
          else       stage[i] <= gateIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stage[i] <= 1'b0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign gateSync = stage[STAGES-1];
endmodule

// File: rtl/pwt_datapath.sv
module pwt_datapath
  import pwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             cntZero,
  output logic             cmpHit,
  output logic             zeroHit
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpQ;
  logic [CNT_W-1:0] decVal;

  assign decVal  = cntQ - 1'b1;
  assign cntZero = (cntQ == '0);
  assign cmpHit  = strb.dec && (decVal == cmpQ);
  assign zeroHit = strb.dec && (decVal == '0);
  assign cntVal  = cntQ;
  assign cmpVal  = cmpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      cmpQ <= '0;
    end else begin
      if (strb.wrCmp) cmpQ <= wrData;
      if (strb.load)     cntQ <= '1;
      else if (strb.dec) cntQ <= decVal;
    end
  end

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.dec) |=> $stable(cntQ));

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0) && !strb.load |=> (cntQ == '0));

  // R3
  load_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (cntQ == '1));
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       gateSync,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       cntZero,
  input  logic       cmpHit,
  input  logic       zeroHit,
  output dpStrobe_t  strb,
  output logic [7:0] ctrlReg,
  output logic [7:0] statusReg
);
  runState_e state, stateNext;
  logic [7:0] ctrlQ;
  logic       loaded;
  logic       enableAll;
  logic       runLive;
  logic       tgSet;
  logic [7:0] clrMask;
  logic       tgF, comF, tcF, toF;
  logic       onF;

  assign enableAll = ctrlQ[CB_RUN] & ctrlQ[CB_PRE] & ctrlQ[CB_GATE] &
                     (ctrlQ[MODE_LSB +: MODE_W] == MODE_PW);
  assign runLive   = (state == ST_RUN) && enableAll && gateSync;
  assign tgSet     = (state == ST_RUN) && enableAll && !gateSync;
  assign clrMask   = (wrEn && wrAddr == ADDR_STAT) ? wrData : 8'h00;
  assign onF       = (state == ST_ARMED) || (state == ST_RUN);

  always_comb begin
    strb.load  = runLive && tick && !loaded;
    strb.dec   = runLive && tick && loaded && !cntZero;
    strb.wrCmp = wrEn && (wrAddr == ADDR_CMP);
  end

  always_comb begin
    stateNext = state;
    if (!enableAll) stateNext = ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  stateNext = ST_ARMED;
        ST_ARMED: if (gateSync) stateNext = ST_RUN;
        ST_RUN:   if (!gateSync) stateNext = ST_DONE;
        default:  stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ctrlQ  <= 8'h00;
      loaded <= 1'b0;
    end else begin
      state <= stateNext;
      if (wrEn && wrAddr == ADDR_CTRL) ctrlQ <= wrData;
      if (state != ST_RUN)  loaded <= 1'b0;
      else if (strb.load)   loaded <= 1'b1;
    end
  end

  // flags: a set event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgF  <= 1'b0;
      comF <= 1'b0;
      tcF  <= 1'b0;
      toF  <= 1'b0;
    end else begin
      if (tgSet)                tgF <= 1'b1;
      else if (clrMask[SB_TG])  tgF <= 1'b0;
      if (zeroHit)              comF <= 1'b0;
      else if (cmpHit)          comF <= 1'b1;
      else if (clrMask[SB_COM]) comF <= 1'b0;
      if (cmpHit)               tcF <= 1'b1;
      else if (clrMask[SB_TC])  tcF <= 1'b0;
      if (zeroHit)              toF <= 1'b1;
      else if (clrMask[SB_TO])  toF <= 1'b0;
    end
  end

  always_comb begin
    statusReg          = 8'h00;
    statusReg[SB_ON]   = onF;
    statusReg[SB_TG]   = tgF;
    statusReg[SB_COM]  = comF;
    statusReg[SB_TC]   = tcF;
    statusReg[SB_TO]   = toF;
    statusReg[SB_GATE] = gateSync;
  end
  assign ctrlReg = ctrlQ;

  // R1
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enableAll |=> !onF);

  // R4
  gate_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgSet |=> tgF && !onF);

  // R5
  single_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) && enableAll |=> (state == ST_DONE));

  // R6
  cmp_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpHit && !zeroHit |=> comF && tcF);

  // R7
  timeout_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroHit |=> toF && !comF);
endmodule

// File: rtl/gated_pw_timer.sv
module gated_pw_timer
  import pwt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             gateIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData
);
  logic             gateSync;
  dpStrobe_t        strb;
  logic [CNT_W-1:0] cntVal, cmpVal;
  logic             cntZero, cmpHit, zeroHit;
  logic [7:0]       ctrlReg, statusReg;

  pwt_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .gateIn(gateIn), .gateSync(gateSync)
  );

  pwt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(cntTick), .gateSync(gateSync),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData[7:0]),
    .cntZero(cntZero), .cmpHit(cmpHit), .zeroHit(zeroHit),
    .strb(strb), .ctrlReg(ctrlReg), .statusReg(statusReg)
  );

  pwt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cntVal(cntVal), .cmpVal(cmpVal), .cntZero(cntZero),
    .cmpHit(cmpHit), .zeroHit(zeroHit)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CTRL: rdData = CNT_W'(ctrlReg);
      ADDR_CMP:  rdData = cmpVal;
      ADDR_STAT: rdData = CNT_W'(statusReg);
      default:   rdData = cntVal;
    endcase
  end
endmodule

// File: tb/gated_pw_timer_test.sv
`timescale 1ns/1ps
module gated_pw_timer_test;
  localparam int CW = 16;
  localparam logic [15:0] ENA = 16'h0047;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cntTick = 1'b0;
  logic          gateIn = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrAddr = 2'd0;
  logic [CW-1:0] wrData = '0;
  logic [1:0]    rdAddr = 2'd0;
  logic [CW-1:0] rdData;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gated_pw_timer uut (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .gateIn(gateIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  typedef struct packed {
    logic [15:0] cmp;
    logic [15:0] nTicks;
    logic [15:0] expCnt;
    logic [7:0]  expStat;
  } vec_t;

  // status after a finished run: TG=bit1; COM=bit2, TC=bit3 on a compare hit
  localparam vec_t VECS [5] = '{
    '{16'h1234, 16'd4,  16'hFFFC, 8'h02},
    '{16'hFFFD, 16'd5,  16'hFFFB, 8'h0E},
    '{16'hFFFF, 16'd1,  16'hFFFF, 8'h02},
    '{16'hFFF6, 16'd10, 16'hFFF6, 8'h0E},
    '{16'hFFF5, 16'd10, 16'hFFF6, 8'h02}
  };

  task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    testCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [CW-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [CW-1:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTicks(input int n);
    repeat (n) begin
      cntTick = 1'b1;
      @(negedge clk);
      cntTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int n);
    gateIn = 1'b1;
    waitCyc(4);
    pulseTicks(n);
    gateIn = 1'b0;
    waitCyc(4);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [CW-1:0] v;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R10 reset state
    regRead(2'd0, v); check("R10 ctrl reset", v, 16'h0000);
    regRead(2'd1, v); check("R10 cmp reset", v, 16'h0000);
    regRead(2'd2, v); check("R10 status reset", v, 16'h0000);
    regRead(2'd3, v); check("R10 count reset", v, 16'h0000);

    // R2 gate level in idle, two-edge latency
    gateIn = 1'b1;
    waitCyc(1);
    regRead(2'd2, v); check("R2 gate not yet seen", v, 16'h0000);
    waitCyc(1);
    regRead(2'd2, v); check("R2 gate level high", v, 16'h0020);
    gateIn = 1'b0;
    waitCyc(3);
    regRead(2'd2, v); check("R2 gate level low", v, 16'h0000);

    // R1 enable only with all bits and mode 100
    regWrite(2'd0, 16'h0043);
    waitCyc(2);
    regRead(2'd2, v); check("R1 no gate enable", v, 16'h0000);
    regWrite(2'd0, 16'h0057);
    waitCyc(2);
    regRead(2'd2, v); check("R1 wrong mode", v, 16'h0000);
    regWrite(2'd0, ENA);
    waitCyc(2);
    regRead(2'd2, v); check("R1 enabled ON", v, 16'h0001);
    regRead(2'd0, v); check("R10 ctrl readback", v, ENA);

    // R3 R4 R6 table of measurements
    for (int i = 0; i < 5; i++) begin
      regWrite(2'd0, 16'h0000);
      regWrite(2'd2, 16'h001E);
      regWrite(2'd1, VECS[i].cmp);
      regWrite(2'd0, ENA);
      measure(int'(VECS[i].nTicks));
      regRead(2'd3, v); check($sformatf("R3 R4 count vec %0d", i), v, VECS[i].expCnt);
      regRead(2'd2, v); check($sformatf("R4 R6 status vec %0d", i), v, {8'h00, VECS[i].expStat});
    end
    regRead(2'd1, v); check("R10 cmp readback", v, 16'hFFF5);

    // R5 single shot: later gate pulse ignored
    measure(3);
    regRead(2'd3, v); check("R5 count frozen", v, 16'hFFF6);
    regRead(2'd2, v); check("R5 status unchanged", v, 16'h0002);

    // R8 write-one-to-clear
    regWrite(2'd2, 16'h0000);
    regRead(2'd2, v); check("R8 zero write keeps", v, 16'h0002);
    regWrite(2'd2, 16'h0002);
    regRead(2'd2, v); check("R8 one write clears", v, 16'h0000);

    // R9 run bit cleared mid-measurement, then re-armed
    regWrite(2'd0, 16'h0000);
    regWrite(2'd1, 16'h1000);
    regWrite(2'd0, ENA);
    gateIn = 1'b1;
    waitCyc(4);
    pulseTicks(3);
    regRead(2'd3, v); check("R9 counting", v, 16'hFFFD);
    regWrite(2'd0, 16'h0000);
    waitCyc(1);
    regRead(2'd2, v); check("R9 idle ON clear", v, 16'h0020);
    pulseTicks(2);
    regRead(2'd3, v); check("R9 idle no count", v, 16'hFFFD);
    gateIn = 1'b0;
    waitCyc(4);
    regWrite(2'd0, ENA);
    waitCyc(1);
    regRead(2'd2, v); check("R9 re-armed ON", v, 16'h0001);
    measure(2);
    regRead(2'd3, v); check("R9 new measurement", v, 16'hFFFE);
    regRead(2'd2, v); check("R9 new status", v, 16'h0002);

    // R7 timeout with compare at zero (compare and timeout same update)
    regWrite(2'd0, 16'h0000);
    regWrite(2'd2, 16'h001E);
    regWrite(2'd1, 16'h0000);
    regWrite(2'd0, ENA);
    gateIn = 1'b1;
    waitCyc(4);
    cntTick = 1'b1;
    waitCyc(65540);
    cntTick = 1'b0;
    waitCyc(1);
    regRead(2'd3, v); check("R7 count held at zero", v, 16'h0000);
    regRead(2'd2, v); check("R7 R6 TO TC set COM clear", v, 16'h0039);
    gateIn = 1'b0;
    waitCyc(4);
    regRead(2'd2, v); check("R7 R4 after gate drop", v, 16'h001A);
    regRead(2'd3, v); check("R7 count still zero", v, 16'h0000);

    finish();
  end
endmodule